// File: doc/BRIEF.md
# Slot-Based Power-Down Sequencer

This block turns off a set of supply outputs in a fixed order. Each output is a voltage rail, a general-purpose output or the reset line, and each one is given a down-slot number. After a start pulse the block walks through eight slots in turn. Each slot waits for its programmed number of half-millisecond ticks. When the slot ends, the block drops the enable of every output assigned to that slot.

Rails switched off in one slot must discharge before the next slot may end. The block checks each such rail against a low-voltage status input. A rail only holds the sequence when its active discharge is enabled. If a rail is still high after a timeout, the sequence goes on anyway and a residual-voltage flag is raised for that rail. A global bypass removes the hold but keeps the flags.

After slot 7 there is one extra tail phase, which checks the rails of the last slot. A one-cycle done pulse then marks the end of the run. The time base is a tick input that pulses once every half millisecond.

Top module: `pwrdn_slot_seq`

## Requirements
- R1: While reset is low and after it is released, every out_en bit is 1, every rv_flag bit is 0 and done is 0.
- R2: Output i reads its 4-bit slot code from slot_code[4i+3:4i]. Codes 0 to 7 select that slot. Codes 8 to 15 act as slot 7. The output's out_en bit falls on the clock edge that ends its slot.
- R3: Slot k reads its 2-bit duration code from dur_code[2k+1:2k]. Codes 0, 1, 2 and 3 give 0, 3, 6 and 20 ticks. The tick counter restarts at 0 when a slot begins. A slot can end only at an edge where its count has reached its duration. With tick held high, an ungated slot therefore lasts duration+1 cycles, counted from the edge that sampled start.
- R4: Rail r is output r, for r below N_RAIL. A rail that was disabled in slot k-1 holds slot k open while that rail has dis_en[r]=1 and rail_low[r]=0. The slot then ends at the first edge at which the rail reads low, provided the duration has also elapsed.
- R5: A held slot is released once its tick count reaches eight times its own duration. For duration code 0 the limit is 24 ticks. The limits for codes 0, 1, 2 and 3 are therefore 24, 24, 48 and 160.
- R6: A rail with dis_en[r]=0 never holds a slot. Timing for that slot depends on its duration alone.
- R7: With bypass=1, no rail holds any slot.
- R8: At the edge that ends slot k, rv_flag[r] is set for every rail of slot k-1 whose rail_low[r] is 0. This happens whatever dis_en and bypass are. Once set, a flag stays set until reset.
- R9: After slot 7 comes a tail phase. The tail uses duration code 0 and checks the slot-7 rails in the same way. When the tail ends, done is 1 for exactly one cycle and the block returns to idle.
- R10: A start pulse that arrives while a sequence is running has no effect on its timing.
- R11: An out_en bit that has fallen never rises again before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Half-millisecond time-base pulse |
| start | input | 1 | Starts the power-down sequence when idle |
| slot_code | input | 4*N_OUT | Down-slot code per output |
| dur_code | input | 2*N_SLOT | Duration code per slot |
| dis_en | input | N_RAIL | Active discharge enabled per rail |
| rail_low | input | N_RAIL | Rail is below the discharge threshold |
| bypass | input | 1 | Skips the discharge hold |
| out_en | output | N_OUT | Enable per output, 1 = on |
| rv_flag | output | N_RAIL | Residual-voltage flag per rail |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
Tick is held high, so every result is due at an exact cycle count after the edge that samples start. Each slot adds its duration plus one cycle, or its timeout plus one cycle when it is held. An output falls in the cycle where its slot ends. The residual flags for a slot's rails are registered at the edge that ends the following slot. The done pulse comes one cycle after slot 7 ends, or a timeout plus one cycle later when a slot-7 rail stays high.

The bench drives its inputs on falling edges and samples on falling edges, with a cycle counter that starts at the start edge. It records the first cycle in which each enable is seen low and the cycle of the done pulse. These are compared with cycle numbers the bench computes from the duration and timeout rules.

// File: rtl/pdseq_pkg.sv
// Shared types and code tables for the power-down sequencer.
// Assumes time is counted in half-millisecond ticks.
package pdseq_pkg;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

    // Duration in ticks for a 2-bit duration code.
    function automatic logic [7:0] dur_ticks(input logic [1:0] code);
        case (code)
            2'd0:    dur_ticks = 8'd0;
            2'd1:    dur_ticks = 8'd3;
            2'd2:    dur_ticks = 8'd6;
            default: dur_ticks = 8'd20;
        endcase
    endfunction

    // Discharge timeout: eight times the duration, 24 ticks for a zero slot.
    function automatic logic [7:0] tmo_ticks(input logic [1:0] code);
        tmo_ticks = (code == 2'd0) ? 8'd24 : 8'(dur_ticks(code) << 3);
    endfunction

    // Codes beyond the last slot fold onto the last slot.
    function automatic int slot_of(input logic [3:0] code, input int n_slot);
        slot_of = (int'(code) >= n_slot) ? n_slot - 1 : int'(code);
    endfunction

endpackage

// File: rtl/pdseq_timer.sv
// Tick counter for the current slot.
// Assumes clr and tick are synchronous; the count saturates at all-ones.
module pdseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    // Restart on clr, otherwise count ticks up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (tick && cnt != '1)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pdseq_decode.sv
// Turns the per-output slot codes into masks: the outputs that belong to
// the current slot, and the rails that were disabled in the slot before it.
// Assumes rails occupy the lowest N_RAIL output positions.
module pdseq_decode #(
    parameter int N_OUT  = 6,
    parameter int N_RAIL = 4,
    parameter int N_SLOT = 8,
    parameter int IDX_W  = 4
) (
    input  logic [4*N_OUT-1:0] slot_code,
    input  logic [IDX_W-1:0]   slot_idx,
    output logic [N_OUT-1:0]   cur_mask,
    output logic [N_RAIL-1:0]  prev_mask
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        // Output g belongs to the slot that is running now.
        assign cur_mask[g] =
            (pdseq_pkg::slot_of(slot_code[4*g +: 4], N_SLOT) == int'(slot_idx));
    end

    for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
        // Rail r was switched off in the slot just before this one.
        assign prev_mask[r] =
            (pdseq_pkg::slot_of(slot_code[4*r +: 4], N_SLOT) + 1 == int'(slot_idx));
    end

endmodule

// File: rtl/pdseq_gate.sv
// Discharge gate. The slot may close when no rail from the previous slot
// with discharge enabled is still high, or when bypass is set. Also reports
// which of those rails are still high, whatever their discharge setting.
module pdseq_gate #(
    parameter int N_RAIL = 4
) (
    input  logic [N_RAIL-1:0] prev_mask,
    input  logic [N_RAIL-1:0] dis_en,
    input  logic [N_RAIL-1:0] rail_low,
    input  logic              bypass,
    output logic              gate_ok,
    output logic [N_RAIL-1:0] stuck
);

    // Rails of the previous slot that have not discharged yet.
    assign stuck   = prev_mask & ~rail_low;
    // Only rails with active discharge may hold the slot open.
    assign gate_ok = bypass || ((stuck & dis_en) == '0);

endmodule

// File: rtl/pwrdn_slot_seq.sv
// Slot-based power-down sequencer, top level.
// Walks slots 0..N_SLOT-1 plus a tail phase. Each slot ends once its
// duration has elapsed and the rails from the previous slot have discharged
// or timed out. Assumes tick pulses once per half millisecond.
module pwrdn_slot_seq #(
    parameter int N_OUT  = 6,
    parameter int N_RAIL = 4,
    parameter int N_SLOT = 8,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [4*N_OUT-1:0]  slot_code,
    input  logic [2*N_SLOT-1:0] dur_code,
    input  logic [N_RAIL-1:0]   dis_en,
    input  logic [N_RAIL-1:0]   rail_low,
    input  logic                bypass,
    output logic [N_OUT-1:0]    out_en,
    output logic [N_RAIL-1:0]   rv_flag,
    output logic                done
);
    import pdseq_pkg::*;

    localparam int IDX_W = $clog2(N_SLOT + 1);

    seq_state_t        st;
    logic [IDX_W-1:0]  slot_idx;
    logic [CNT_W-1:0]  cnt;
    logic [N_OUT-1:0]  cur_mask;
    logic [N_RAIL-1:0] prev_mask;
    logic [N_RAIL-1:0] stuck;
    logic              gate_ok;
    logic [1:0]        cur_code;
    logic              in_slot;
    logic              dur_met;
    logic              tmo_met;
    logic              slot_end;
    logic              go;

    // Duration code of the running slot; the tail phase uses code 0.
    always_comb begin
        in_slot  = (int'(slot_idx) < N_SLOT);
        cur_code = in_slot ? dur_code[2*int'(slot_idx) +: 2] : 2'd0;
    end

    assign dur_met  = (cnt >= CNT_W'(dur_ticks(cur_code)));
    assign tmo_met  = (cnt >= CNT_W'(tmo_ticks(cur_code)));
    assign slot_end = (st == ST_RUN) && dur_met && (gate_ok || tmo_met);
    assign go       = (st == ST_IDLE) && start;

    pdseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go || slot_end),
        .tick  (tick),
        .cnt   (cnt)
    );

    pdseq_decode #(
        .N_OUT  (N_OUT),
        .N_RAIL (N_RAIL),
        .N_SLOT (N_SLOT),
        .IDX_W  (IDX_W)
    ) u_decode (
        .slot_code (slot_code),
        .slot_idx  (slot_idx),
        .cur_mask  (cur_mask),
        .prev_mask (prev_mask)
    );

    pdseq_gate #(.N_RAIL(N_RAIL)) u_gate (
        .prev_mask (prev_mask),
        .dis_en    (dis_en),
        .rail_low  (rail_low),
        .bypass    (bypass),
        .gate_ok   (gate_ok),
        .stuck     (stuck)
    );

    // Sequence state and slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            slot_idx <= '0;
        end else if (go) begin
            st       <= ST_RUN;
            slot_idx <= '0;
        end else if (slot_end) begin
            if (in_slot)
                slot_idx <= slot_idx + 1'b1;
            else
                st <= ST_IDLE;
        end
    end

    // Drop the enables of the closing slot and collect residual-voltage flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en  <= '1;
            rv_flag <= '0;
            done    <= 1'b0;
        end else begin
            done <= slot_end && !in_slot;
            if (slot_end) begin
                rv_flag <= rv_flag | stuck;
                if (in_slot)
                    out_en <= out_en & ~cur_mask;
            end
        end
    end

    // R11: enables only ever fall between resets
    a_r11_en_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en & ~$past(out_en)) == '0);

    // R8: residual flags are sticky
    a_r8_rv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rv_flag) & ~rv_flag) == '0);

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: no output changes before the slot duration has elapsed
    a_r3_hold_duration: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !dur_met) |=> $stable(out_en) && $stable(slot_idx));

    // R4: a held slot keeps every enable until release or timeout
    a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !gate_ok && !tmo_met) |=> $stable(out_en));

    // R10: start while running leaves the slot index unchanged
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && start && !slot_end) |=> $stable(slot_idx));

endmodule

// File: tb/tb_pwrdn_slot_seq.sv
module tb_pwrdn_slot_seq;

    localparam int N_OUT  = 6;
    localparam int N_RAIL = 4;
    localparam int N_SLOT = 8;
    localparam int LIMIT  = 700;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                tick = 1'b1;
    logic                start = 1'b0;
    logic [4*N_OUT-1:0]  slot_code = '0;
    logic [2*N_SLOT-1:0] dur_code = '0;
    logic [N_RAIL-1:0]   dis_en = '1;
    logic [N_RAIL-1:0]   rail_low = '1;
    logic                bypass = 1'b0;
    logic [N_OUT-1:0]    out_en;
    logic [N_RAIL-1:0]   rv_flag;
    logic                done;

    int tests = 0;
    int fails = 0;
    int got_fall [N_OUT];
    int exp_fall [N_OUT];
    int got_done, exp_done, done_cnt;
    logic [N_RAIL-1:0] exp_rv;

    always #4 clk = ~clk;

    pwrdn_slot_seq #(.N_OUT(N_OUT), .N_RAIL(N_RAIL), .N_SLOT(N_SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .slot_code(slot_code), .dur_code(dur_code), .dis_en(dis_en),
        .rail_low(rail_low), .bypass(bypass), .out_en(out_en),
        .rv_flag(rv_flag), .done(done)
    );

    // {slot codes (output 5 in the top nibble), duration codes (slot 7 top)}
    localparam logic [39:0] VEC [4] = '{
        {24'h543210, 16'h0000},
        {24'h701234, 16'hE4E4},
        {24'h333333, 16'h5555},
        {24'h2870F9, 16'hFFFF}
    };

    function automatic int t_dur(input logic [1:0] c);
        case (c) 2'd0: return 0; 2'd1: return 3; 2'd2: return 6; default: return 20; endcase
    endfunction

    function automatic int t_tmo(input logic [1:0] c);
        return (c == 2'd0) ? 24 : 8 * t_dur(c);
    endfunction

    function automatic int slot_of(input logic [3:0] c);
        return (c > 4'd7) ? 7 : int'(c);
    endfunction

    // Expected fall cycles, done cycle and flags for steady rail levels.
    task automatic build_exp();
        int s = 0;
        exp_rv = '0;
        for (int k = 0; k <= N_SLOT; k++) begin
            logic [1:0] c = (k < N_SLOT) ? dur_code[2*k +: 2] : 2'd0;
            bit held = 1'b0;
            for (int r = 0; r < N_RAIL; r++)
                if (slot_of(slot_code[4*r +: 4]) == k - 1 && !rail_low[r]) begin
                    exp_rv[r] = 1'b1;
                    if (dis_en[r] && !bypass) held = 1'b1;
                end
            s += (held ? t_tmo(c) : t_dur(c)) + 1;
            if (k < N_SLOT) begin
                for (int i = 0; i < N_OUT; i++)
                    if (slot_of(slot_code[4*i +: 4]) == k) exp_fall[i] = s;
            end else
                exp_done = s;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Run one sequence; optional rail release and restart at given cycles.
    task automatic run_seq(input int rel_at, input logic [N_RAIL-1:0] rel_val,
                           input int restart_at);
        for (int i = 0; i < N_OUT; i++) got_fall[i] = -1;
        got_done = -1;
        done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < LIMIT; c++) begin
            for (int i = 0; i < N_OUT; i++)
                if (got_fall[i] < 0 && !out_en[i]) got_fall[i] = c;
            if (done) begin
                done_cnt++;
                if (got_done < 0) got_done = c;
            end
            start = (c == restart_at);
            if (c == rel_at) rail_low = rel_val;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < N_OUT; i++)
            check(got_fall[i] == exp_fall[i], "R2/R3", $sformatf("%s out%0d fall", tag, i),
                  got_fall[i], exp_fall[i]);
        check(got_done == exp_done, "R9", {tag, " done cycle"}, got_done, exp_done);
        check(done_cnt == 1, "R9", {tag, " done width"}, done_cnt, 1);
        check(rv_flag == exp_rv, "R8", {tag, " rv flags"}, int'(rv_flag), int'(exp_rv));
        check(out_en == '0, "R11", {tag, " all off at end"}, int'(out_en), 0);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(out_en == '1 && rv_flag == '0 && !done, "R1", "in reset",
              int'({out_en, rv_flag, done}), int'({6'h3F, 4'h0, 1'b0}));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_en == '1 && rv_flag == '0 && !done, "R1", "after reset",
              int'({out_en, rv_flag, done}), int'({6'h3F, 4'h0, 1'b0}));

        // Table of slot/duration patterns, rails discharging at once (R2, R3, R9)
        foreach (VEC[v]) begin
            slot_code = VEC[v][39:16];
            dur_code  = VEC[v][15:0];
            rail_low = '1; dis_en = '1; bypass = 1'b0;
            do_reset();
            build_exp();
            run_seq(-1, '1, -1);
            compare($sformatf("vec%0d", v));
        end

        // R4 R5: rail 0 never discharges, slot 1 waits the full timeout
        slot_code = 24'h543210; dur_code = 16'h5555;
        rail_low = 4'b1110; dis_en = '1; bypass = 1'b0;
        do_reset(); build_exp(); run_seq(-1, '1, -1); compare("r4_r5_timeout");

        // R5 R9: slot-7 rail stuck holds the tail for 24 ticks
        slot_code = 24'h547210; dur_code = 16'h0000;
        rail_low = 4'b0111;
        do_reset(); build_exp(); run_seq(-1, '1, -1); compare("r9_tail_timeout");

        // R6: discharge disabled, no hold, flag still set
        slot_code = 24'h543210; dur_code = 16'h5555;
        rail_low = 4'b1110; dis_en = 4'b1110;
        do_reset(); build_exp(); run_seq(-1, '1, -1); compare("r6_no_discharge");

        // R7: bypass, no hold, flag still set
        rail_low = 4'b1101; dis_en = '1; bypass = 1'b1;
        do_reset(); build_exp(); run_seq(-1, '1, -1); compare("r7_bypass");
        bypass = 1'b0;

        // R4: rail 0 discharges at cycle 60 during slot 1 (duration 20)
        slot_code = 24'h111110; dur_code = 16'h000C;
        rail_low = 4'b1110; dis_en = '1;
        do_reset();
        for (int i = 0; i < N_OUT; i++) exp_fall[i] = (i == 0) ? 1 : 61;
        exp_done = 68; exp_rv = '0;
        run_seq(60, '1, -1); compare("r4_late_release");

        // R10: start pulse in the middle of a run changes nothing
        slot_code = VEC[1][39:16]; dur_code = VEC[1][15:0]; rail_low = '1;
        do_reset(); build_exp(); run_seq(-1, '1, 20); compare("r10_restart");

        finish_up();
    end

endmodule